// File: doc/BRIEF.md
# Paired-Word Load/Store Execution Unit

This block carries out one two-register memory instruction for a 32-bit core. It moves an even/odd register pair to or from memory as two back-to-back word transfers. A start strobe hands it the instruction word. The block then reads the base, offset and data registers through four combinational register-file read ports. It forms the effective address and decides whether the instruction is legal. It drives the two word accesses over a request/ready memory port. Finally it writes the loaded pair and any updated base through a single register-file write port, one register per cycle.

The controller is a six-state machine. From IDLE, `start` leads to CHECK. CHECK latches the operands and the legality verdict and goes either to DONE on a trap or to ACC0. ACC0 waits for `mem_ready`: an abort leads to DONE, otherwise the machine goes to ACC1. ACC1 does the same and, without an abort, goes to WB. WB spends three cycles on its write slots (low data register, high data register, base) and then goes to DONE. DONE raises `done` and returns to IDLE.

A misaligned address raises a data abort when the parameter `ABORT_EN` is 1. When it is 0, the same condition is reported as undefined.

Top module: `pair_ldst_unit`

## Requirements
- R1: Instruction bits [7:4] select the operation. 4'hD is the paired load and 4'hE is the paired store. Any other value ends as undefined with no memory request.
- R2: Bit 22 set selects the offset {instr[11:8], instr[3:0]}, zero-extended. Bit 22 clear selects the full value of the register named in bits [3:0]. Bit 23 set adds the offset to the base (register in bits [19:16]) and bit 23 clear subtracts it.
- R3: Bit 24 set (pre-index) accesses base±offset. Bit 24 clear (post-index) accesses the unmodified base.
- R4: Writeback (bit 21) set while bit 24 is clear ends as undefined with no memory request.
- R5: These cases end as undefined with no memory request: an odd first data register (bits [15:12]) on either operation, first data register 14 on a load, and base register 15 on a store. Base 15 on a load and first data register 14 on a store are legal.
- R6: A nonzero value in address bits [2:0] ends as a data abort with no memory request.
- R7: When post-indexed or writing back, a base register equal to the first or second data register ends as undefined. Misalignment is checked first and wins. Without writeback, a pre-indexed overlap is legal.
- R8: The first word transfers at the access address and the second at that address plus 4. The register named in bits [15:12] pairs with the lower address and the next register pairs with the higher address, for loads and for stores.
- R9: A memory request holds its address, write flag and write data unchanged until `mem_ready` is seen.
- R10: An abort on either memory access ends as a data abort and writes no register at all.
- R11: After a successful access, the base register receives base±offset when post-indexed or when writeback is set, and is not written otherwise. Load writes go in the order: low data register, high data register, base.
- R12: `done` is high for exactly one cycle per instruction. `undef` and `dabort` are only ever high together with `done`, and never both at once.
- R13: After reset, `done`, `undef`, `dabort`, `mem_req` and `rf_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Accepts `instr` when the unit is idle |
| instr | input | 32 | Instruction word |
| rf_base_idx | output | 4 | Read index for the base register |
| rf_base_data | input | 32 | Base register value |
| rf_off_idx | output | 4 | Read index for the offset register |
| rf_off_data | input | 32 | Offset register value |
| rf_lo_idx | output | 4 | Read index for the first data register |
| rf_lo_data | input | 32 | First data register value |
| rf_hi_idx | output | 4 | Read index for the second data register |
| rf_hi_data | input | 32 | Second data register value |
| rf_we | output | 1 | Register write enable |
| rf_widx | output | 4 | Register write index |
| rf_wdata | output | 32 | Register write data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Request accepted this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` |
| mem_abort | input | 1 | Access faulted, valid with `mem_ready` |
| done | output | 1 | Instruction finished (one cycle) |
| undef | output | 1 | Finished as undefined instruction |
| dabort | output | 1 | Finished as data abort |

## Verification
The bench targets the order in which the traps are checked. A misaligned pre-indexed writeback whose base overlaps the data pair must report a data abort. A design that checks overlap first would report undefined instead. The bench also targets the legal look-alikes: a load through base 15, a store from register 14, and a pre-indexed overlap without writeback. A design that traps too eagerly would refuse these. A load whose second word aborts confirms that the already fetched first word never reaches the register file. Varied ready latency and writeback/post-index cases confirm that the base update happens only when it should and in the last write slot.

// File: rtl/pls_pkg.sv
package pls_pkg;

    localparam int REG_IDX_W = 4;
    localparam logic [REG_IDX_W-1:0] LINK_IDX = 4'd14;
    localparam logic [REG_IDX_W-1:0] PC_IDX   = 4'd15;
    localparam logic [3:0] OP_PAIR_LOAD  = 4'hD;
    localparam logic [3:0] OP_PAIR_STORE = 4'hE;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_ACC0,
        ST_ACC1,
        ST_WB,
        ST_DONE
    } pls_state_e;

    typedef enum logic [1:0] {
        RES_OK,
        RES_UNDEF,
        RES_DABT
    } pls_result_e;

    typedef struct packed {
        logic                 is_load;
        logic                 is_store;
        logic                 wb;
        logic                 imm;
        logic                 up;
        logic                 pre;
        logic [REG_IDX_W-1:0] rn;
        logic [REG_IDX_W-1:0] rd;
        logic [REG_IDX_W-1:0] rd_hi;
        logic [REG_IDX_W-1:0] rm;
        logic [7:0]           imm8;
    } pls_fields_t;

endpackage

// File: rtl/pls_decode.sv
module pls_decode
    import pls_pkg::*;
#(
    parameter int INSTR_W = 32
) (
    input  logic [INSTR_W-1:0] instr,
    output pls_fields_t        f
);

    logic unused_bits;
    assign unused_bits = ^{instr[INSTR_W-1:25], instr[20]};

    always_comb begin
        f.is_load  = (instr[7:4] == OP_PAIR_LOAD);
        f.is_store = (instr[7:4] == OP_PAIR_STORE);
        f.wb       = instr[21];
        f.imm      = instr[22];
        f.up       = instr[23];
        f.pre      = instr[24];
        f.rn       = instr[19:16];
        f.rd       = instr[15:12];
        f.rd_hi    = REG_IDX_W'(instr[15:12] + 4'd1);
        f.rm       = instr[3:0];
        f.imm8     = {instr[11:8], instr[3:0]};
    end

endmodule

// File: rtl/pls_agu.sv
module pls_agu
    import pls_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ALIGN_BITS = 3
) (
    input  pls_fields_t       f,
    input  logic [DATA_W-1:0] base,
    input  logic [DATA_W-1:0] reg_off,
    output logic [DATA_W-1:0] sum,
    output logic [DATA_W-1:0] addr,
    output logic              misaligned
);

    logic [DATA_W-1:0] offset;

    always_comb begin
        offset     = f.imm ? {{(DATA_W-8){1'b0}}, f.imm8} : reg_off;
        sum        = f.up ? (base + offset) : (base - offset);
        addr       = f.pre ? sum : base;
        misaligned = |addr[ALIGN_BITS-1:0];
    end

endmodule

// File: rtl/pls_legal.sv
module pls_legal
    import pls_pkg::*;
#(
    parameter bit ABORT_EN = 1'b1
) (
    input  pls_fields_t f,
    input  logic        misaligned,
    output pls_result_e res
);

    logic base_moves;
    assign base_moves = !f.pre || f.wb;

    always_comb begin
        if (!f.is_load && !f.is_store)
            res = RES_UNDEF;
        else if (f.wb && !f.pre)
            res = RES_UNDEF;
        else if (f.is_store && f.rn == PC_IDX)
            res = RES_UNDEF;
        else if (f.rd[0] || (f.is_load && f.rd == LINK_IDX))
            res = RES_UNDEF;
        else if (misaligned)
            res = ABORT_EN ? RES_DABT : RES_UNDEF;
        else if (base_moves && (f.rn == f.rd || f.rn == f.rd_hi))
            res = RES_UNDEF;
        else
            res = RES_OK;
    end

    // R5: a load into the link register pair never passes
    always_comb begin
        if (f.is_load && f.rd == LINK_IDX)
            assert_link_pair_trap_R5: assert (res != RES_OK);
    end

    // R6: a misaligned address never reaches memory
    always_comb begin
        if (misaligned)
            assert_misalign_trap_R6: assert (res != RES_OK);
    end

endmodule

// File: rtl/pair_ldst_unit.sv
module pair_ldst_unit
    import pls_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int INSTR_W    = 32,
    parameter int ALIGN_BITS = 3,
    parameter bit ABORT_EN   = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [INSTR_W-1:0]   instr,
    output logic [REG_IDX_W-1:0] rf_base_idx,
    input  logic [DATA_W-1:0]    rf_base_data,
    output logic [REG_IDX_W-1:0] rf_off_idx,
    input  logic [DATA_W-1:0]    rf_off_data,
    output logic [REG_IDX_W-1:0] rf_lo_idx,
    input  logic [DATA_W-1:0]    rf_lo_data,
    output logic [REG_IDX_W-1:0] rf_hi_idx,
    input  logic [DATA_W-1:0]    rf_hi_data,
    output logic                 rf_we,
    output logic [REG_IDX_W-1:0] rf_widx,
    output logic [DATA_W-1:0]    rf_wdata,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [DATA_W-1:0]    mem_addr,
    output logic [DATA_W-1:0]    mem_wdata,
    input  logic                 mem_ready,
    input  logic [DATA_W-1:0]    mem_rdata,
    input  logic                 mem_abort,
    output logic                 done,
    output logic                 undef,
    output logic                 dabort
);

    localparam int WORD_BYTES = DATA_W / 8;
    localparam int WB_SLOTS   = 3;
    localparam int SLOT_W     = $clog2(WB_SLOTS);
    localparam logic [SLOT_W-1:0] SLOT_LO   = SLOT_W'(0);
    localparam logic [SLOT_W-1:0] SLOT_HI   = SLOT_W'(1);
    localparam logic [SLOT_W-1:0] SLOT_BASE = SLOT_W'(WB_SLOTS - 1);

    pls_state_e           state, state_nx;
    logic [INSTR_W-1:0]   instr_q;
    pls_fields_t          f;
    pls_result_e          check_res, result_q;
    logic [DATA_W-1:0]    sum_c, addr_c;
    logic                 misaligned_c;
    logic [DATA_W-1:0]    sum_q, addr_q;
    logic [DATA_W-1:0]    wd_lo_q, wd_hi_q;
    logic [DATA_W-1:0]    rd_lo_q, rd_hi_q;
    logic [SLOT_W-1:0]    slot_q;
    logic                 base_moves;

    pls_decode #(.INSTR_W(INSTR_W)) u_decode (
        .instr (instr_q),
        .f     (f)
    );

    pls_agu #(.DATA_W(DATA_W), .ALIGN_BITS(ALIGN_BITS)) u_agu (
        .f          (f),
        .base       (rf_base_data),
        .reg_off    (rf_off_data),
        .sum        (sum_c),
        .addr       (addr_c),
        .misaligned (misaligned_c)
    );

    pls_legal #(.ABORT_EN(ABORT_EN)) u_legal (
        .f          (f),
        .misaligned (misaligned_c),
        .res        (check_res)
    );

    assign base_moves  = !f.pre || f.wb;
    assign rf_base_idx = f.rn;
    assign rf_off_idx  = f.rm;
    assign rf_lo_idx   = f.rd;
    assign rf_hi_idx   = f.rd_hi;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_CHECK;
            ST_CHECK: state_nx = (check_res == RES_OK) ? ST_ACC0 : ST_DONE;
            ST_ACC0:  if (mem_ready) state_nx = mem_abort ? ST_DONE : ST_ACC1;
            ST_ACC1:  if (mem_ready) state_nx = mem_abort ? ST_DONE : ST_WB;
            ST_WB:    if (slot_q == SLOT_BASE) state_nx = ST_DONE;
            ST_DONE:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // Operand and result capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            instr_q  <= '0;
            result_q <= RES_OK;
            sum_q    <= '0;
            addr_q   <= '0;
            wd_lo_q  <= '0;
            wd_hi_q  <= '0;
            rd_lo_q  <= '0;
            rd_hi_q  <= '0;
            slot_q   <= SLOT_LO;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        instr_q  <= instr;
                        result_q <= RES_OK;
                    end
                end
                ST_CHECK: begin
                    result_q <= check_res;
                    sum_q    <= sum_c;
                    addr_q   <= addr_c;
                    wd_lo_q  <= rf_lo_data;
                    wd_hi_q  <= rf_hi_data;
                    slot_q   <= SLOT_LO;
                end
                ST_ACC0: begin
                    if (mem_ready) begin
                        if (mem_abort) result_q <= RES_DABT;
                        else           rd_lo_q  <= mem_rdata;
                    end
                end
                ST_ACC1: begin
                    if (mem_ready) begin
                        if (mem_abort) result_q <= RES_DABT;
                        else           rd_hi_q  <= mem_rdata;
                    end
                end
                ST_WB:   slot_q <= slot_q + SLOT_W'(1);
                ST_DONE: slot_q <= SLOT_LO;
                default: slot_q <= SLOT_LO;
            endcase
        end
    end

    // Outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = addr_q;
        mem_wdata = wd_lo_q;
        rf_we     = 1'b0;
        rf_widx   = f.rd;
        rf_wdata  = rd_lo_q;
        done      = 1'b0;
        undef     = 1'b0;
        dabort    = 1'b0;
        unique case (state)
            ST_IDLE, ST_CHECK: ;
            ST_ACC0: begin
                mem_req   = 1'b1;
                mem_we    = f.is_store;
            end
            ST_ACC1: begin
                mem_req   = 1'b1;
                mem_we    = f.is_store;
                mem_addr  = addr_q + DATA_W'(WORD_BYTES);
                mem_wdata = wd_hi_q;
            end
            ST_WB: begin
                if (slot_q == SLOT_LO) begin
                    rf_we    = f.is_load;
                end else if (slot_q == SLOT_HI) begin
                    rf_we    = f.is_load;
                    rf_widx  = f.rd_hi;
                    rf_wdata = rd_hi_q;
                end else begin
                    rf_we    = base_moves;
                    rf_widx  = f.rn;
                    rf_wdata = sum_q;
                end
            end
            ST_DONE: begin
                done   = 1'b1;
                undef  = (result_q == RES_UNDEF);
                dabort = (result_q == RES_DABT);
            end
            default: ;
        endcase
    end

    // R9: an unanswered request keeps its contents
    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) &&
                                     $stable(mem_we) && $stable(mem_wdata)));

    // R8: second transfer sits one word above the first
    assert_second_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACC1 && $past(state) == ST_ACC0) |->
            (mem_addr == $past(mem_addr) + DATA_W'(WORD_BYTES)));

    // R4 (and R1, R5, R6): a failed check issues no memory request
    assert_trap_no_access_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CHECK && check_res != RES_OK) |=> !mem_req);

    // R10: registers are only written on a clean run
    assert_clean_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (result_q == RES_OK));

    // R12: done is a single-cycle pulse
    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12: at most one trap flag, and only with done
    assert_flag_with_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({undef, dabort}) && ((undef || dabort) -> done));

endmodule

// File: tb/pair_ldst_unit_test.sv
module pair_ldst_unit_test;

    localparam int NVEC   = 18;
    localparam int MWORDS = 256;
    localparam logic [7:0] ABORT_WORD = 8'hFD;  // byte address 0x3F4

    // {instr, code(0 ok,1 undef,2 dabort), expected request count, requirement}
    localparam logic [39:0] VEC [NVEC] = '{
        {32'h01C241D0, 2'd0, 2'd2, 4'd3},   // R3 pre-index add, imm
        {32'h012680E1, 2'd0, 2'd2, 4'd11},  // R11 pre-index sub reg, writeback store
        {32'h00C300D8, 2'd0, 2'd2, 4'd11},  // R11 post-index load
        {32'h0045A2E0, 2'd0, 2'd2, 4'd3},   // R3 post-index sub store
        {32'h00E241D0, 2'd1, 2'd0, 4'd4},   // R4 writeback with post-index
        {32'h01C251D0, 2'd1, 2'd0, 4'd5},   // R5 odd data register
        {32'h01C2E1D0, 2'd1, 2'd0, 4'd5},   // R5 load into register 14
        {32'h01CF41E0, 2'd1, 2'd0, 4'd5},   // R5 store with base 15
        {32'h01CF41D0, 2'd0, 2'd2, 4'd5},   // R5 load with base 15 is legal
        {32'h01C240D4, 2'd2, 2'd0, 4'd6},   // R6 misaligned
        {32'h01E440D4, 2'd2, 2'd0, 4'd7},   // R7 misaligned beats overlap
        {32'h00C540D8, 2'd1, 2'd0, 4'd7},   // R7 post-index overlap
        {32'h01C540D8, 2'd0, 2'd2, 4'd7},   // R7 pre-index overlap, no writeback
        {32'h01E981E0, 2'd1, 2'd0, 4'd7},   // R7 writeback overlap store
        {32'h01C241B0, 2'd1, 2'd0, 4'd1},   // R1 unknown operation
        {32'h01EF23D0, 2'd2, 2'd2, 4'd10},  // R10 second word aborts
        {32'h018260E3, 2'd0, 2'd2, 4'd2},   // R2 register offset add store
        {32'h01C1E0E0, 2'd0, 2'd2, 4'd8}    // R8 store from register 14
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] instr = '0;
    logic [3:0]  rf_base_idx, rf_off_idx, rf_lo_idx, rf_hi_idx, rf_widx;
    logic [31:0] rf_base_data, rf_off_data, rf_lo_data, rf_hi_data, rf_wdata;
    logic        rf_we, mem_req, mem_we, done, undef, dabort;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ready = 1'b0;
    logic        mem_abort = 1'b0;
    logic [31:0] mem_rdata = '0;

    logic [31:0] regs [16];
    logic [31:0] mem [MWORDS];
    logic [31:0] exp_regs [16];
    logic [31:0] exp_mem [MWORDS];
    logic [3:0]  wlog [8];
    logic [3:0]  exp_wlog [8];
    int          nwr, exp_nwr, nreq, delay_sel, wait_cnt;
    int          checks = 0, errors = 0, cycles = 0;
    logic        pend;
    logic [31:0] pend_addr;

    always #4 clk = ~clk;

    pair_ldst_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .rf_base_idx(rf_base_idx), .rf_base_data(rf_base_data),
        .rf_off_idx(rf_off_idx), .rf_off_data(rf_off_data),
        .rf_lo_idx(rf_lo_idx), .rf_lo_data(rf_lo_data),
        .rf_hi_idx(rf_hi_idx), .rf_hi_data(rf_hi_data),
        .rf_we(rf_we), .rf_widx(rf_widx), .rf_wdata(rf_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .mem_abort(mem_abort), .done(done), .undef(undef), .dabort(dabort)
    );

    assign rf_base_data = regs[rf_base_idx];
    assign rf_off_data  = regs[rf_off_idx];
    assign rf_lo_data   = regs[rf_lo_idx];
    assign rf_hi_data   = regs[rf_hi_idx];

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    // Register file write side and write-order log
    always @(posedge clk) begin
        if (rf_we) begin
            regs[rf_widx] <= rf_wdata;
            if (nwr < 8) wlog[nwr] <= rf_widx;
            nwr <= nwr + 1;
        end
    end

    // Memory responder, acting on the falling edge
    always @(negedge clk) begin
        if (mem_ready) begin
            mem_ready = 1'b0;
            mem_abort = 1'b0;
            wait_cnt  = 0;
            pend      = 1'b0;
        end else if (mem_req) begin
            if (pend)  // R9: address held while waiting
                chk(mem_addr == pend_addr, "R9 held address", mem_addr, pend_addr);
            pend      = 1'b1;
            pend_addr = mem_addr;
            if (wait_cnt >= delay_sel) begin
                mem_ready = 1'b1;
                mem_abort = (mem_addr[9:2] == ABORT_WORD);
                mem_rdata = mem[mem_addr[9:2]];
                if (mem_we && !mem_abort) mem[mem_addr[9:2]] = mem_wdata;
                nreq++;
            end else begin
                wait_cnt++;
            end
        end
    end

    task automatic init_state();
        for (int i = 0; i < 16; i++) begin
            regs[i]     = 32'(i * 64);
            exp_regs[i] = 32'(i * 64);
        end
        for (int j = 0; j < MWORDS; j++) begin
            mem[j]     = 32'hC0DE0000 + 32'(j);
            exp_mem[j] = 32'hC0DE0000 + 32'(j);
        end
        nwr = 0; exp_nwr = 0; nreq = 0; wait_cnt = 0; pend = 1'b0;
    endtask

    // Expected effect of a successful instruction, from the requirements
    task automatic model_ok(input logic [31:0] ins);
        logic [3:0]  rn, rd;
        logic [31:0] base, off, sum, a;
        logic        ld, p, w;
        rn   = ins[19:16];
        rd   = ins[15:12];
        ld   = (ins[7:4] == 4'hD);
        p    = ins[24];
        w    = ins[21];
        base = exp_regs[rn];
        off  = ins[22] ? {24'd0, ins[11:8], ins[3:0]} : exp_regs[ins[3:0]];
        sum  = ins[23] ? base + off : base - off;
        a    = p ? sum : base;
        if (ld) begin
            exp_regs[rd]       = exp_mem[a[9:2]];
            exp_regs[rd + 1]   = exp_mem[a[9:2] + 8'd1];
            exp_wlog[exp_nwr++] = rd;
            exp_wlog[exp_nwr++] = rd + 4'd1;
        end else begin
            exp_mem[a[9:2]]        = exp_regs[rd];
            exp_mem[a[9:2] + 8'd1] = exp_regs[rd + 1];
        end
        if (!p || w) begin
            exp_regs[rn]        = sum;
            exp_wlog[exp_nwr++] = rn;
        end
    endtask

    task automatic run_one(input logic [31:0] ins, output logic [1:0] code,
                           output bit seen);
        int n;
        @(negedge clk);
        instr = ins;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        seen  = 1'b0;
        code  = 2'd3;
        n     = 0;
        while (!seen && n < 200) begin
            if (done) begin
                seen = 1'b1;
                code = dabort ? 2'd2 : (undef ? 2'd1 : 2'd0);
            end else begin
                @(negedge clk);
                n++;
            end
        end
        @(negedge clk);
        chk(done == 1'b0, "R12 done width", 32'(done), 32'd0);
    endtask

    initial begin
        logic [1:0]  code;
        bit          seen;
        logic [39:0] v;
        init_state();
        delay_sel = 0;
        repeat (3) @(negedge clk);
        // R13: reset state
        chk({done, undef, dabort, mem_req, rf_we} == 5'b0, "R13 reset outputs",
            {27'd0, done, undef, dabort, mem_req, rf_we}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({done, mem_req, rf_we} == 3'b0, "R13 idle after reset",
            {29'd0, done, mem_req, rf_we}, 32'd0);

        for (int k = 0; k < NVEC; k++) begin
            v = VEC[k];
            init_state();
            delay_sel = k % 3;
            if (v[7:6] == 2'd0) model_ok(v[39:8]);
            run_one(v[39:8], code, seen);
            chk(seen, $sformatf("R%0d done seen, vector %0d", v[3:0], k),
                32'(seen), 32'd1);
            chk(code == v[7:6], $sformatf("R%0d outcome, vector %0d", v[3:0], k),
                32'(code), 32'(v[7:6]));
            chk(nreq == int'(v[5:4]),
                $sformatf("R%0d request count, vector %0d", v[3:0], k),
                32'(nreq), 32'(v[5:4]));
            for (int r = 0; r < 16; r++)
                if (regs[r] !== exp_regs[r])
                    chk(1'b0, $sformatf("R8/R10/R11 reg %0d, vector %0d", r, k),
                        regs[r], exp_regs[r]);
            for (int m = 0; m < MWORDS; m++)
                if (mem[m] !== exp_mem[m])
                    chk(1'b0, $sformatf("R8 mem word %0d, vector %0d", m, k),
                        mem[m], exp_mem[m]);
            chk(nwr == exp_nwr, $sformatf("R11 write count, vector %0d", k),
                32'(nwr), 32'(exp_nwr));
            for (int q = 0; q < exp_nwr && q < nwr; q++)
                chk(wlog[q] == exp_wlog[q],
                    $sformatf("R11 write order slot %0d, vector %0d", q, k),
                    32'(wlog[q]), 32'(exp_wlog[q]));
        end

        // R12: start pulses while busy do not create an extra done
        init_state();
        delay_sel = 2;
        @(negedge clk);
        instr = 32'h01C241D0;
        start = 1'b1;
        repeat (12) @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        chk(done == 1'b0, "R12 quiet after run", 32'(done), 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule